// File: doc/BRIEF.md
# Disk Task-File Status Register Controller

This block keeps the 8-bit status byte that a parallel disk task-file interface presents to its host. It follows the command life cycle from a command register write strobe, a completion pulse, a buffer-ready pulse and a data-strobe stream. From these it produces the busy and data-request indications, and it re-asserts busy at every sector boundary. It also tracks a latched write fault, drive readiness, seek completion and an error flag, and passes an index input straight through.

Host resets are handled in two ways. A level hardware reset input and a one-cycle soft reset pulse both start reset processing. Busy stays set until a reset-done pulse arrives or a bounded reset period runs out.

Host reads pass through a small multiplexer. While busy shows 1, a read of any task-file address returns the status byte in place of the addressed register.

Top module: `dsk_status_ctrl`

## Requirements
- R1: A command write (`cmd_wr_i`) taken while status bit 7 (busy) reads 0 and no reset is active is accepted. Bit 7 reads 1 after the next clock edge. A `cmd_done_i` pulse during an accepted command clears bit 7 and bit 3 at the following edge.
- R2: A `buf_ready_i` pulse during an accepted command sets bit 3 (data request) at the next edge. While bit 3 is 1, bit 7 reads 0 even though the command is still in progress.
- R3: When bit 7 reads 1, `host_rdata_o` equals the status byte for every `rd_addr_i`. When bit 7 reads 0, address 7 returns the status byte and any other address returns `reg_rdata_i`.
- R4: Bit 7 reads 1 from the edge after `host_rst_i` rises or `soft_rst_i` pulses. It stays 1 while `host_rst_i` is held. After release it clears at the edge that sees `rst_done_i`, or at the latest on the RST_MAX_CYC-th edge with the reset released. A reset also clears bits 5, 3 and 0 and ends any command.
- R5: For a sector command (`cmd_long_i` = 0 at acceptance), each data strobe taken while bit 3 is 1 counts BYTES_PER_STB bytes. On the strobe that completes SECTOR_BYTES bytes, bit 3 falls and bit 7 rises at the next edge.
- R6: For a long command (`cmd_long_i` = 1 at acceptance), the boundary of R5 comes only after SECTOR_BYTES + ECC_BYTES bytes.
- R7: A `wr_fault_i` pulse during an accepted command sets bit 5. Bit 5 then holds through command completion until the next accepted command or a reset clears it. A fault pulse with no command in progress leaves bit 5 unchanged.
- R8: Bit 6 (ready) is 0 until `spin_ready_i` has been 1 for a clock edge. It is then 1 unless the last accepted command saw `not_ready_i` = 1, in which case it is 0 until a command is accepted with `not_ready_i` = 0.
- R9: Bit 4 (seek complete) becomes 1 on the edge after `spinup_done_i` is seen. From then on it stays 1, through host and soft resets, until `rst_n`.
- R10: Bit 2 always reads 0 and bit 1 equals `index_i`. Bit 0 (error) is set by `err_i` during an accepted command and is cleared by the next accepted command or a reset.
- R11: A command write while bit 7 reads 1 is ignored. Bits 5 and 0 keep their values, and the command keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| host_rst_i | input | 1 | Host hardware reset level, active high |
| soft_rst_i | input | 1 | Soft reset pulse from the control register |
| rst_done_i | input | 1 | Reset processing finished pulse |
| cmd_wr_i | input | 1 | Host write to the command register |
| cmd_long_i | input | 1 | Command carries ECC bytes per sector (long) |
| not_ready_i | input | 1 | Drive not ready when a command is received |
| cmd_done_i | input | 1 | Command completion pulse |
| buf_ready_i | input | 1 | Sector buffer ready for host transfer |
| xfer_stb_i | input | 1 | One host data transfer of BYTES_PER_STB bytes |
| wr_fault_i | input | 1 | Write fault pulse |
| err_i | input | 1 | Command error pulse |
| spin_ready_i | input | 1 | Spindle at steady speed |
| spinup_done_i | input | 1 | Spin-up control finished |
| index_i | input | 1 | Index mark, passed through |
| rd_addr_i | input | 3 | Task-file address of the host read |
| reg_rdata_i | input | 8 | Contents of the addressed task-file register |
| status_o | output | 8 | Status byte |
| host_rdata_o | output | 8 | Read data returned to the host |

## Verification
The assertions check, on every cycle, that busy and data request are never shown together and that any read during busy returns the status byte. They also check that an accepted command, a held host reset and a sector boundary each raise busy one edge later, that a latched fault survives until a command write or a reset, that seek complete never drops, and that ready follows a missing spindle. The bench scenarios show what the assertions cannot: the exact strobe counts of sector and long boundaries, the length of the reset timeout, a reset ending on the done pulse, and an ignored command write that leaves the fault and error flags untouched. They also show the not-ready path of the ready bit and that faults outside a command are dropped.

// File: rtl/dsk_status_pkg.sv
// Shared definitions for the task-file status controller.
// The packed struct fixes the bit order the host decodes: busy in bit 7
// down to error in bit 0.
package dsk_status_pkg;

    typedef struct packed {
        logic bsy;
        logic drdy;
        logic df;
        logic dsc;
        logic drq;
        logic zero;
        logic idx;
        logic err;
    } status_t;

    // Task-file address of the status register.
    localparam logic [2:0] STAT_ADDR = 3'd7;

endpackage

// File: rtl/dsk_stat_rstseq.sv
// Reset sequencer: tracks host hardware reset and soft reset processing.
// Assumes host_rst_i is a synchronised level and soft_rst_i a one-cycle pulse.
// Processing ends on rst_done_i or after RST_MAX_CYC edges with reset released.
module dsk_stat_rstseq #(
    parameter int unsigned RST_MAX_CYC = 750_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_rst_i,
    input  logic soft_rst_i,
    input  logic rst_done_i,
    output logic in_rst_o,
    output logic rst_evt_o
);
    localparam int unsigned TW = $clog2(RST_MAX_CYC + 1);

    logic          in_rst_q;
    logic [TW-1:0] tmr_q;

    // Reset request seen this cycle: restarts processing.
    assign rst_evt_o = host_rst_i | soft_rst_i;
    assign in_rst_o  = in_rst_q;

    // Hold reset processing and count the bounded period once released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_rst_q <= 1'b0;
            tmr_q    <= '0;
        end else if (rst_evt_o) begin
            in_rst_q <= 1'b1;
            tmr_q    <= '0;
        end else if (in_rst_q) begin
            if (rst_done_i || tmr_q == TW'(RST_MAX_CYC - 1)) begin
                in_rst_q <= 1'b0;
                tmr_q    <= '0;
            end else begin
                tmr_q <= tmr_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/dsk_stat_blkcnt.sv
// Sector byte counter: counts data strobes during a data request phase and
// flags the strobe that completes a block. A long command adds ECC bytes.
// Assumes SECTOR_BYTES and ECC_BYTES are multiples of BYTES_PER_STB.
module dsk_stat_blkcnt #(
    parameter int unsigned SECTOR_BYTES  = 512,
    parameter int unsigned ECC_BYTES     = 4,
    parameter int unsigned BYTES_PER_STB = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic en_i,
    input  logic long_i,
    output logic blk_end_o
);
    localparam int unsigned SECT_STB = SECTOR_BYTES / BYTES_PER_STB;
    localparam int unsigned LONG_STB = (SECTOR_BYTES + ECC_BYTES) / BYTES_PER_STB;
    localparam int unsigned CW       = $clog2(LONG_STB + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;

    // Last strobe index of the current block, chosen by command kind.
    assign last      = long_i ? CW'(LONG_STB - 1) : CW'(SECT_STB - 1);
    assign blk_end_o = en_i && (cnt_q == last);

    // Advance per strobe, wrap at the block end, clear on command start or reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i || blk_end_o) begin
            cnt_q <= '0;
        end else if (en_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/dsk_stat_flags.sv
// Condition flags: latched write fault, error, drive ready and seek complete.
// Assumes accept_i marks the cycle a command is taken and act_i a command in progress.
module dsk_stat_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_evt_i,
    input  logic accept_i,
    input  logic act_i,
    input  logic not_ready_i,
    input  logic wr_fault_i,
    input  logic err_i,
    input  logic spin_ready_i,
    input  logic spinup_done_i,
    output logic df_o,
    output logic err_o,
    output logic drdy_o,
    output logic dsc_o
);
    logic df_q, err_q, nr_q, spin_q, dsc_q;

    // Write fault: latched during a command, cleared by a new command or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_evt_i)      df_q <= 1'b0;
        else if (accept_i)            df_q <= 1'b0;
        else if (act_i && wr_fault_i) df_q <= 1'b1;
    end

    // Error: same life cycle as the fault flag.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_evt_i)  err_q <= 1'b0;
        else if (accept_i)        err_q <= 1'b0;
        else if (act_i && err_i)  err_q <= 1'b1;
    end

    // Not-ready condition sampled when a command is received.
    always_ff @(posedge clk) begin
        if (!rst_n)        nr_q <= 1'b0;
        else if (accept_i) nr_q <= not_ready_i;
    end

    // Registered spindle-ready level.
    always_ff @(posedge clk) begin
        if (!rst_n) spin_q <= 1'b0;
        else        spin_q <= spin_ready_i;
    end

    // Seek complete: sticky once spin-up has finished.
    always_ff @(posedge clk) begin
        if (!rst_n)             dsc_q <= 1'b0;
        else if (spinup_done_i) dsc_q <= 1'b1;
    end

    assign df_o   = df_q;
    assign err_o  = err_q;
    assign drdy_o = spin_q & ~nr_q;
    assign dsc_o  = dsc_q;
endmodule

// File: rtl/dsk_status_ctrl.sv
// Task-file status controller top: command life cycle (busy / data request),
// status byte assembly and busy-time read redirection.
// Assumes all inputs are synchronous to clk; the read mux is combinational.
module dsk_status_ctrl
    import dsk_status_pkg::*;
#(
    parameter int unsigned SECTOR_BYTES  = 512,
    parameter int unsigned ECC_BYTES     = 4,
    parameter int unsigned BYTES_PER_STB = 2,
    parameter int unsigned RST_MAX_CYC   = 750_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_rst_i,
    input  logic       soft_rst_i,
    input  logic       rst_done_i,
    input  logic       cmd_wr_i,
    input  logic       cmd_long_i,
    input  logic       not_ready_i,
    input  logic       cmd_done_i,
    input  logic       buf_ready_i,
    input  logic       xfer_stb_i,
    input  logic       wr_fault_i,
    input  logic       err_i,
    input  logic       spin_ready_i,
    input  logic       spinup_done_i,
    input  logic       index_i,
    input  logic [2:0] rd_addr_i,
    input  logic [7:0] reg_rdata_i,
    output logic [7:0] status_o,
    output logic [7:0] host_rdata_o
);
    logic    in_rst, rst_evt;
    logic    act_q, drq_q, long_q;
    logic    bsy_vis, accept, blk_end;
    logic    df, err, drdy, dsc;
    status_t st;

    dsk_stat_rstseq #(.RST_MAX_CYC(RST_MAX_CYC)) u_rstseq (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_rst_i (host_rst_i),
        .soft_rst_i (soft_rst_i),
        .rst_done_i (rst_done_i),
        .in_rst_o   (in_rst),
        .rst_evt_o  (rst_evt)
    );

    dsk_stat_blkcnt #(
        .SECTOR_BYTES  (SECTOR_BYTES),
        .ECC_BYTES     (ECC_BYTES),
        .BYTES_PER_STB (BYTES_PER_STB)
    ) u_blkcnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (accept | rst_evt | cmd_done_i),
        .en_i      (xfer_stb_i & drq_q & act_q),
        .long_i    (long_q),
        .blk_end_o (blk_end)
    );

    dsk_stat_flags u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .rst_evt_i     (rst_evt),
        .accept_i      (accept),
        .act_i         (act_q),
        .not_ready_i   (not_ready_i),
        .wr_fault_i    (wr_fault_i),
        .err_i         (err_i),
        .spin_ready_i  (spin_ready_i),
        .spinup_done_i (spinup_done_i),
        .df_o          (df),
        .err_o         (err),
        .drdy_o        (drdy),
        .dsc_o         (dsc)
    );

    // Busy as seen by the host: command or reset in progress, hidden during a data request.
    assign bsy_vis = (act_q | in_rst) & ~drq_q;
    assign accept  = cmd_wr_i & ~bsy_vis & ~in_rst & ~rst_evt;

    // Command in progress: set on acceptance, ended by completion or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_evt) act_q <= 1'b0;
        else if (accept)       act_q <= 1'b1;
        else if (cmd_done_i)   act_q <= 1'b0;
    end

    // Command kind captured at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)      long_q <= 1'b0;
        else if (accept) long_q <= cmd_long_i;
    end

    // Data request: raised by a ready buffer, dropped at block end, completion or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_evt)                     drq_q <= 1'b0;
        else if (accept || cmd_done_i || blk_end)  drq_q <= 1'b0;
        else if (buf_ready_i && act_q)             drq_q <= 1'b1;
    end

    // Status byte assembly.
    always_comb begin
        st.bsy  = bsy_vis;
        st.drdy = drdy;
        st.df   = df;
        st.dsc  = dsc;
        st.drq  = drq_q;
        st.zero = 1'b0;
        st.idx  = index_i;
        st.err  = err;
    end

    assign status_o = st;

    // Host read path: status address, or any address while busy, returns status.
    always_comb begin
        if (st.bsy || rd_addr_i == STAT_ADDR) host_rdata_o = st;
        else                                  host_rdata_o = reg_rdata_i;
    end
endmodule

// File: rtl/dsk_status_chk.sv
// Property checker for the status controller, attached by bind.
module dsk_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_rst_i,
    input logic       soft_rst_i,
    input logic       cmd_wr_i,
    input logic       spin_ready_i,
    input logic       blk_end,
    input logic [7:0] status_o,
    input logic [7:0] host_rdata_o
);
    // R2: busy and data request never shown together.
    p_bsy_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(status_o[7] && status_o[3]));

    // R3: reads during busy return the status byte.
    p_busy_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[7] |-> host_rdata_o == status_o);

    // R1: accepted command write shows busy one edge later.
    p_cmd_bsy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_i && !status_o[7] && !host_rst_i && !soft_rst_i) |=> status_o[7]);

    // R4: held host reset shows busy.
    p_rst_bsy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        host_rst_i |=> status_o[7]);

    // R5: sector boundary drops data request and raises busy.
    p_blk_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        blk_end |=> (status_o[7] && !status_o[3]));

    // R7: latched fault holds until a command write or reset.
    p_df_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[5] && !cmd_wr_i && !host_rst_i && !soft_rst_i) |=> status_o[5]);

    // R8: no spindle, no ready.
    p_drdy_spin_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !spin_ready_i |=> !status_o[6]);

    // R9: seek complete never drops.
    p_dsc_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[4] |=> status_o[4]);
endmodule

bind dsk_status_ctrl dsk_status_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_rst_i   (host_rst_i),
    .soft_rst_i   (soft_rst_i),
    .cmd_wr_i     (cmd_wr_i),
    .spin_ready_i (spin_ready_i),
    .blk_end      (blk_end),
    .status_o     (status_o),
    .host_rdata_o (host_rdata_o)
);

// File: tb/test_dsk_status_ctrl.sv
// Directed bench for the status controller: one task per scenario.
module test_dsk_status_ctrl;
    localparam int unsigned RSTMAX = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_rst_i = 0, soft_rst_i = 0, rst_done_i = 0, cmd_wr_i = 0;
    logic cmd_long_i = 0, not_ready_i = 0, cmd_done_i = 0, buf_ready_i = 0;
    logic xfer_stb_i = 0, wr_fault_i = 0, err_i = 0, spin_ready_i = 0;
    logic spinup_done_i = 0, index_i = 0;
    logic [2:0] rd_addr_i = 3'd0;
    logic [7:0] reg_rdata_i = 8'h00;
    logic [7:0] status_o, host_rdata_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dsk_status_ctrl #(
        .SECTOR_BYTES (512), .ECC_BYTES (4), .BYTES_PER_STB (2), .RST_MAX_CYC (RSTMAX)
    ) i_dsk_status_ctrl (.*);

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cmd(input logic lng, input logic nr);
        cmd_long_i = lng; not_ready_i = nr; cmd_wr_i = 1; tick(1);
        cmd_wr_i = 0; not_ready_i = 0;
    endtask

    task automatic pulse_done();   cmd_done_i = 1;  tick(1); cmd_done_i = 0;  endtask
    task automatic pulse_buf();    buf_ready_i = 1; tick(1); buf_ready_i = 0; endtask
    task automatic strobes(input int n); xfer_stb_i = 1; tick(n); xfer_stb_i = 0; endtask

    task automatic t_reset_state();
        chk("R10 reset status", status_o, 8'h00);
        index_i = 1; #1;
        chk("R10 index pass", status_o, 8'h02);
        index_i = 0;
    endtask

    task automatic t_drdy();
        chk("R8 ready before spindle", status_o[6], 0);
        spin_ready_i = 1; tick(1);
        chk("R8 ready after spindle", status_o[6], 1);
        cmd(0, 1);
        chk("R8 not-ready command", status_o[6], 0);
        pulse_done();
        cmd(0, 0);
        chk("R8 ready restored", status_o[6], 1);
        pulse_done();
    endtask

    task automatic t_dsc();
        chk("R9 seek before spinup", status_o[4], 0);
        spinup_done_i = 1; tick(1); spinup_done_i = 0; tick(3);
        chk("R9 seek sticky", status_o[4], 1);
    endtask

    task automatic t_cmd_basic();
        cmd(0, 0);
        chk("R1 busy after command", status_o[7], 1);
        chk("R10 bit2 zero", status_o[2], 0);
        pulse_done();
        chk("R1 busy cleared", status_o[7], 0);
    endtask

    task automatic t_sector();
        cmd(0, 0);
        pulse_buf();
        chk("R2 drq set", status_o[3], 1);
        chk("R2 busy masked", status_o[7], 0);
        strobes(255);
        chk("R5 drq before boundary", status_o[3], 1);
        strobes(1);
        chk("R5 drq at boundary", status_o[3], 0);
        chk("R5 busy at boundary", status_o[7], 1);
        pulse_done();
        chk("R1 done after sector", status_o[7], 0);
    endtask

    task automatic t_long();
        cmd(1, 0);
        pulse_buf();
        strobes(256);
        chk("R6 drq after 512 bytes", status_o[3], 1);
        strobes(2);
        chk("R6 drq after ECC", status_o[3], 0);
        chk("R6 busy after ECC", status_o[7], 1);
        pulse_done();
    endtask

    task automatic t_df_err();
        cmd(0, 0);
        wr_fault_i = 1; err_i = 1; tick(1); wr_fault_i = 0; err_i = 0;
        chk("R7 fault latched", status_o[5], 1);
        chk("R10 error set", status_o[0], 1);
        cmd(0, 0);
        chk("R11 fault kept on busy write", status_o[5], 1);
        chk("R11 error kept on busy write", status_o[0], 1);
        pulse_done(); tick(3);
        chk("R7 fault across completion", status_o[5], 1);
        cmd(0, 0);
        chk("R7 fault cleared by command", status_o[5], 0);
        chk("R10 error cleared by command", status_o[0], 0);
        pulse_done();
        wr_fault_i = 1; tick(1); wr_fault_i = 0;
        chk("R7 idle fault ignored", status_o[5], 0);
    endtask

    task automatic t_read();
        rd_addr_i = 3'd2; reg_rdata_i = 8'hA5; #1;
        chk("R3 idle register read", host_rdata_o, 8'hA5);
        rd_addr_i = 3'd7; #1;
        chk("R3 idle status read", host_rdata_o, status_o);
        cmd(0, 0);
        rd_addr_i = 3'd2; #1;
        chk("R3 busy read redirected", host_rdata_o, status_o);
        chk("R3 busy read value", host_rdata_o[7], 1);
        pulse_done();
    endtask

    task automatic t_hw_reset();
        cmd(0, 0);
        wr_fault_i = 1; tick(1); wr_fault_i = 0;
        pulse_buf();
        host_rst_i = 1; tick(3);
        chk("R4 busy in hw reset", status_o[7], 1);
        chk("R4 drq cleared", status_o[3], 0);
        chk("R4 fault cleared", status_o[5], 0);
        host_rst_i = 0; tick(RSTMAX - 1);
        chk("R4 busy before timeout", status_o[7], 1);
        tick(1);
        chk("R4 busy after timeout", status_o[7], 0);
    endtask

    task automatic t_soft_reset();
        soft_rst_i = 1; tick(1); soft_rst_i = 0;
        chk("R4 busy after soft reset", status_o[7], 1);
        tick(5);
        chk("R4 busy holds", status_o[7], 1);
        rst_done_i = 1; tick(1); rst_done_i = 0;
        chk("R4 busy ends on done", status_o[7], 0);
        chk("R9 seek kept over reset", status_o[4], 1);
    endtask

    initial begin
        tick(3);
        rst_n = 1;
        tick(1);
        t_reset_state();
        t_drdy();
        t_dsc();
        t_cmd_basic();
        t_sector();
        t_long();
        t_df_err();
        t_read();
        t_hw_reset();
        t_soft_reset();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule